// File: doc/BRIEF.md
# Digitized Pulse Feature Extractor

This block takes the sample stream of one detector channel, digitized at 100 MHz as 14-bit unsigned codes, and reduces each shaped pulse to a compact record. While the window input is low, every valid sample enters a 25-deep history whose rounded mean becomes the baseline of the next pulse. While the window input is high, valid samples are captured (up to 32 of them). Running peak and integral values are kept as the samples arrive.

When the window input is sampled low again, the block finishes the record in one combinational pass and registers it. The record holds the baseline, the peak height above baseline (the charge estimate), the signed integral above baseline, and a leading-edge time. The time is taken where the pulse first reaches 30 % of its peak and is refined by linear interpolation to 1/16 of a sample. The record also carries a pile-up flag, raised when integral over peak falls outside a programmable band, and a no-hit flag for pulses too small to time.

Top module: `pfx_top`

## Requirements
- R1: The baseline is round-half-up of the mean of the 25 most recent samples that had smp_valid high while win was low, before the first sample of the window; history slots not yet filled since reset count as zero.
- R2: res_peak equals the largest captured window sample minus the baseline, or 0 when no captured sample exceeds the baseline.
- R3: res_integral is the signed sum of (sample minus baseline) over all captured window samples.
- R4: With thr = floor(3 * peak / 10) and a[k] = sample k minus baseline, i is the lowest capture index with a[i] >= thr. res_time is 0 when i is 0. Otherwise it is 16*(i-1) + floor(16*(thr - a[i-1]) / (a[i] - a[i-1])). Bits [8:4] carry the whole sample index and bits [3:0] the sixteenths.
- R5: res_nohit is 1 when the peak is 0 or below cfg_min_peak; a no-hit record carries res_time = 0 and res_pileup = 0.
- R6: For a hit, res_pileup is 1 when 16*integral < cfg_ratio_lo*peak or 16*integral > cfg_ratio_hi*peak. The two ratio inputs are unsigned with 4 fractional bits.
- R7: res_valid is a one-cycle pulse in the cycle after the first clock edge at which win is low following a captured window sample. The record fields hold their values until the next pulse.
- R8: A window starts only with a sample that has both smp_valid and win high. Cycles with smp_valid low change neither the history nor the window sums.
- R9: Only the first 32 valid samples of a window are captured. Later samples of the same window affect no record field and do not enter the baseline history.
- R10: After reset, res_valid and all record fields are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Unsigned sample code |
| win | input | 1 | Pulse window, high while the pulse is being taken |
| cfg_min_peak | input | 14 | Smallest peak that still counts as a hit |
| cfg_ratio_lo | input | 8 | Lower integral/peak bound, 4.4 fixed point |
| cfg_ratio_hi | input | 8 | Upper integral/peak bound, 4.4 fixed point |
| res_valid | output | 1 | Record strobe |
| res_baseline | output | 14 | Baseline of the pulse |
| res_peak | output | 14 | Peak height above baseline |
| res_integral | output | 21 | Signed integral above baseline |
| res_time | output | 9 | Crossing time, 5.4 fixed point in samples |
| res_nohit | output | 1 | Pulse too small to time |
| res_pileup | output | 1 | Integral/peak outside the band |

## Verification
A stale or misordered history entry shows up as a baseline off by a few codes in the very next record. Because every other field is measured against the baseline, the same error then shifts the peak, the integral and often the time. A wrong running maximum, integral or capture count appears in the record emitted the cycle after the window closes. A fault in the crossing search or the interpolation divider shows as a time field off by whole samples or by sixteenths. Any of these faults is visible one cycle after the window that exercised it, so the bench compares every field of every record against arithmetic over the samples it drove.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

    localparam int DW    = 14;                  // sample width
    localparam int NBASE = 25;                  // baseline history depth
    localparam int WMAX  = 32;                  // capture depth per window
    localparam int RW    = 8;                   // ratio bound width (4.4)
    localparam int FW    = 4;                   // fractional time bits

    localparam int IDXW  = $clog2(WMAX);
    localparam int CNTW  = IDXW + 1;
    localparam int TW    = IDXW + FW;
    localparam int SW    = DW + $clog2(NBASE);
    localparam int IW    = DW + IDXW + 2;
    localparam int CW    = IW + FW + RW;

    typedef struct packed {
        logic [DW-1:0]        baseline;
        logic [DW-1:0]        peak;
        logic signed [IW-1:0] integral;
        logic [TW-1:0]        t_cross;
        logic                 nohit;
        logic                 pileup;
    } pfx_result_t;

    // floor(16*num/den) for 0 < num <= den: restoring division, FW+1 quotient bits
    function automatic logic [FW:0] frac_div(input logic [DW+1:0] num,
                                             input logic [DW+1:0] den);
        logic [DW+FW+2:0] rem;
        logic [DW+FW+2:0] dsh;
        logic [FW:0]      q;
        rem = {1'b0, num, {FW{1'b0}}};
        q   = '0;
        for (int b = FW; b >= 0; b--) begin
            dsh = {1'b0, den, {FW{1'b0}}} >> (FW - b);
            if (rem >= dsh) begin
                rem  = rem - dsh;
                q[b] = 1'b1;
            end
        end
        return q;
    endfunction

endpackage

// File: rtl/pfx_baseline.sv
module pfx_baseline
    import pfx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          smp_valid,
    input  logic          win,
    input  logic [DW-1:0] smp_data,
    output logic [DW-1:0] bl_now
);
    localparam int RK = SW + $clog2(NBASE) + 1;
    localparam logic [RK:0] RECIP =
        (RK+1)'(((64'd1 << RK) + 64'(NBASE) - 64'd1) / 64'(NBASE));
    localparam logic [SW-1:0] SUM_MAX = SW'(NBASE * ((1 << DW) - 1));

    logic [DW-1:0]      ring [NBASE];
    logic [SW-1:0]      sum;
    logic               ring_en;
    logic [SW:0]        s_round;
    logic [SW+RK+1:0]   prod;

    assign ring_en = smp_valid && !win;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum <= '0;
            for (int k = 0; k < NBASE; k++) ring[k] <= '0;
        end else if (ring_en) begin
            ring[0] <= smp_data;
            for (int k = 1; k < NBASE; k++) ring[k] <= ring[k-1];
            sum <= sum + SW'(smp_data) - SW'(ring[NBASE-1]);
        end
    end

    // round half up, division by the depth done as a reciprocal multiply
    always_comb begin
        s_round = (SW+1)'(sum) + (SW+1)'(NBASE / 2);
        prod    = (SW+RK+2)'(s_round) * (SW+RK+2)'(RECIP);
        bl_now  = prod[RK +: DW];
    end

    // R1
    sum_range_chk: assert property (@(posedge clk) disable iff (rst)
        sum <= SUM_MAX);
    // R8
    hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ring_en |=> $stable(sum));

endmodule

// File: rtl/pfx_capture.sv
module pfx_capture
    import pfx_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic                      win,
    input  logic [DW-1:0]             smp_data,
    input  logic [DW-1:0]             bl_now,
    output logic                      close_o,
    output logic [WMAX-1:0][DW-1:0]   buf_o,
    output logic [CNTW-1:0]           cnt_o,
    output logic [DW-1:0]             max_o,
    output logic signed [IW-1:0]      integ_o,
    output logic [DW-1:0]             bl_o
);
    logic                 collecting;
    logic [CNTW-1:0]      base_cnt;
    logic [DW-1:0]        bl_use;
    logic                 accept;
    logic signed [IW-1:0] delta;

    always_comb begin
        base_cnt = collecting ? cnt_o : '0;
        bl_use   = collecting ? bl_o : bl_now;
        accept   = smp_valid && win && (base_cnt < CNTW'(WMAX));
        delta    = $signed({{(IW-DW){1'b0}}, smp_data})
                 - $signed({{(IW-DW){1'b0}}, bl_use});
        close_o  = collecting && !win;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            collecting <= 1'b0;
            buf_o      <= '0;
            cnt_o      <= '0;
            max_o      <= '0;
            integ_o    <= '0;
            bl_o       <= '0;
        end else if (accept) begin
            buf_o[base_cnt[IDXW-1:0]] <= smp_data;
            cnt_o      <= base_cnt + 1'b1;
            max_o      <= (!collecting || smp_data > max_o) ? smp_data : max_o;
            integ_o    <= (collecting ? integ_o : '0) + delta;
            collecting <= 1'b1;
            if (!collecting) bl_o <= bl_now;
        end else if (close_o) begin
            collecting <= 1'b0;
        end
    end

    // R9
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_o <= CNTW'(WMAX));
    // R8
    gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (collecting && !smp_valid) |=> ($stable(cnt_o) && $stable(integ_o)));

endmodule

// File: rtl/pfx_resolve.sv
module pfx_resolve
    import pfx_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      close_i,
    input  logic [WMAX-1:0][DW-1:0]   buf_i,
    input  logic [CNTW-1:0]           cnt_i,
    input  logic [DW-1:0]             max_i,
    input  logic signed [IW-1:0]      integ_i,
    input  logic [DW-1:0]             bl_i,
    input  logic [DW-1:0]             cfg_min_peak,
    input  logic [RW-1:0]             cfg_ratio_lo,
    input  logic [RW-1:0]             cfg_ratio_hi,
    output logic                      res_valid,
    output pfx_result_t               res_q
);
    logic signed [DW+1:0] a [WMAX];
    logic [DW-1:0]        pk;
    logic [DW+1:0]        thr3, thr;
    logic [IDXW-1:0]      idx;
    logic signed [DW+1:0] a_prev, num_s, den_s;
    logic [FW:0]          q;
    logic [TW-1:0]        tq;
    logic                 nohit, pileup;
    logic signed [CW-1:0] ilhs, lo_p, hi_p;
    logic [RW+DW-1:0]     lop, hip;

    always_comb begin
        for (int k = 0; k < WMAX; k++)
            a[k] = $signed({2'b00, buf_i[k]}) - $signed({2'b00, bl_i});
    end

    always_comb begin
        pk   = (max_i > bl_i) ? max_i - bl_i : '0;
        thr3 = (DW+2)'(pk) * (DW+2)'(3);
        thr  = thr3 / (DW+2)'(10);
        idx  = '0;
        for (int k = WMAX - 1; k >= 0; k--)
            if (CNTW'(k) < cnt_i && a[k] >= $signed(thr)) idx = IDXW'(k);
        a_prev = (idx != '0) ? a[idx - IDXW'(1)] : '0;
        num_s  = $signed(thr) - a_prev;
        den_s  = a[idx] - a_prev;
        q      = frac_div(num_s, den_s);
        tq     = (idx == '0) ? '0
               : {idx - IDXW'(1), {FW{1'b0}}} + TW'(q);
        nohit  = (pk == '0) || (pk < cfg_min_peak);
        lop    = (RW+DW)'(cfg_ratio_lo) * (RW+DW)'(pk);
        hip    = (RW+DW)'(cfg_ratio_hi) * (RW+DW)'(pk);
        ilhs   = $signed({{(CW-IW-FW){integ_i[IW-1]}}, integ_i, {FW{1'b0}}});
        lo_p   = $signed({{(CW-RW-DW){1'b0}}, lop});
        hi_p   = $signed({{(CW-RW-DW){1'b0}}, hip});
        pileup = !nohit && ((ilhs < lo_p) || (ilhs > hi_p));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            res_valid <= close_i;
            if (close_i) begin
                res_q.baseline <= bl_i;
                res_q.peak     <= pk;
                res_q.integral <= integ_i;
                res_q.t_cross  <= nohit ? '0 : tq;
                res_q.nohit    <= nohit;
                res_q.pileup   <= pileup;
            end
        end
    end

    // R5
    nohit_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_q.nohit) |-> (res_q.t_cross == '0 && !res_q.pileup));
    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
    // R2
    hit_peak_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_q.nohit) |-> (res_q.peak != '0));
    // R7
    hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(close_i) |-> $stable(res_q));

endmodule

// File: rtl/pfx_top.sv
module pfx_top
    import pfx_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  smp_valid,
    input  logic [DW-1:0]         smp_data,
    input  logic                  win,
    input  logic [DW-1:0]         cfg_min_peak,
    input  logic [RW-1:0]         cfg_ratio_lo,
    input  logic [RW-1:0]         cfg_ratio_hi,
    output logic                  res_valid,
    output logic [DW-1:0]         res_baseline,
    output logic [DW-1:0]         res_peak,
    output logic signed [IW-1:0]  res_integral,
    output logic [TW-1:0]         res_time,
    output logic                  res_nohit,
    output logic                  res_pileup
);
    logic [DW-1:0]             bl_now, bl_lat, max_v;
    logic                      close_w;
    logic [WMAX-1:0][DW-1:0]   buf_w;
    logic [CNTW-1:0]           cnt_w;
    logic signed [IW-1:0]      integ_w;
    pfx_result_t               res_q;

    pfx_baseline u_base (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .win(win),
        .smp_data(smp_data), .bl_now(bl_now)
    );

    pfx_capture u_cap (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .win(win),
        .smp_data(smp_data), .bl_now(bl_now), .close_o(close_w),
        .buf_o(buf_w), .cnt_o(cnt_w), .max_o(max_v), .integ_o(integ_w),
        .bl_o(bl_lat)
    );

    pfx_resolve u_res (
        .clk(clk), .rst(rst), .close_i(close_w), .buf_i(buf_w), .cnt_i(cnt_w),
        .max_i(max_v), .integ_i(integ_w), .bl_i(bl_lat),
        .cfg_min_peak(cfg_min_peak), .cfg_ratio_lo(cfg_ratio_lo),
        .cfg_ratio_hi(cfg_ratio_hi), .res_valid(res_valid), .res_q(res_q)
    );

    assign res_baseline = res_q.baseline;
    assign res_peak     = res_q.peak;
    assign res_integral = res_q.integral;
    assign res_time     = res_q.t_cross;
    assign res_nohit    = res_q.nohit;
    assign res_pileup   = res_q.pileup;

endmodule

// File: tb/tb_pfx_top.sv
module tb_pfx_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid, win;
    logic [13:0] smp_data;
    logic [13:0] cfg_min_peak;
    logic [7:0]  cfg_ratio_lo, cfg_ratio_hi;
    logic        res_valid, res_nohit, res_pileup;
    logic [13:0] res_baseline, res_peak;
    logic signed [20:0] res_integral;
    logic [8:0]  res_time;

    always #4 clk = ~clk;

    pfx_top dut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
        .win(win), .cfg_min_peak(cfg_min_peak), .cfg_ratio_lo(cfg_ratio_lo),
        .cfg_ratio_hi(cfg_ratio_hi), .res_valid(res_valid),
        .res_baseline(res_baseline), .res_peak(res_peak),
        .res_integral(res_integral), .res_time(res_time),
        .res_nohit(res_nohit), .res_pileup(res_pileup)
    );

    int errs = 0;
    int checks = 0;
    int hist [25];
    int wv [64];

    task automatic check(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push_hist(input int v);
        for (int k = 24; k > 0; k--) hist[k] = hist[k-1];
        hist[0] = v;
    endtask

    function automatic int clip(input int v);
        if (v < 0) return 0;
        if (v > 16383) return 16383;
        return v;
    endfunction

    task automatic idle_sample(input int v);
        @(negedge clk);
        smp_valid = 1'b1; win = 1'b0; smp_data = 14'(clip(v));
        push_hist(clip(v));
    endtask

    task automatic fill_base(input int b, input int jit, input int n);
        for (int k = 0; k < n; k++) idle_sample(b + ((k * 7) % 5 - 2) * jit);
    endtask

    task automatic make_pulse(input int base, input int amp, input int pre,
                              input int rise, input int fall, input int n);
        for (int k = 0; k < n; k++) begin
            int v;
            if (k < pre) v = base;
            else if (k < pre + rise) v = base + amp * (k - pre + 1) / rise;
            else if (k < pre + rise + fall) v = base + amp * (pre + rise + fall - k - 1) / fall;
            else v = base;
            wv[k] = clip(v);
        end
    endtask

    // drives n window samples (optional gap), closes, checks the record
    task automatic run_window(input string tag, input int n, input int gap_at);
        int s, bl, m, mx, pk, integ, thr, i, t, q, nh, pu;
        int a [64];
        s = 0;
        for (int k = 0; k < 25; k++) s += hist[k];
        bl = (2 * s + 25) / 50;
        m = (n < 32) ? n : 32;
        mx = 0; integ = 0;
        for (int k = 0; k < m; k++) begin
            a[k] = wv[k] - bl;
            if (wv[k] > mx) mx = wv[k];
            integ += a[k];
        end
        pk = (mx > bl) ? mx - bl : 0;
        thr = (3 * pk) / 10;
        i = 0;
        for (int k = m - 1; k >= 0; k--) if (a[k] >= thr) i = k;
        if (i == 0) t = 0;
        else begin
            q = (16 * (thr - a[i-1])) / (a[i] - a[i-1]);
            t = 16 * (i - 1) + q;
        end
        nh = (pk == 0 || pk < int'(cfg_min_peak)) ? 1 : 0;
        if (nh != 0) t = 0;
        pu = (nh == 0 && (16 * integ < int'(cfg_ratio_lo) * pk
                       || 16 * integ > int'(cfg_ratio_hi) * pk)) ? 1 : 0;

        for (int k = 0; k < n; k++) begin
            if (k == gap_at) begin
                @(negedge clk); smp_valid = 1'b0; win = 1'b1; smp_data = 14'h3FFF;
            end
            @(negedge clk); smp_valid = 1'b1; win = 1'b1; smp_data = 14'(wv[k]);
        end
        @(negedge clk); smp_valid = 1'b0; win = 1'b0;
        @(negedge clk);
        check({tag, " R7 valid"}, longint'(res_valid), 1);
        check({tag, " R1 baseline"}, longint'(res_baseline), bl);
        check({tag, " R2 peak"}, longint'(res_peak), pk);
        check({tag, " R3 integral"}, longint'(res_integral), integ);
        check({tag, " R4 time"}, longint'(res_time), t);
        check({tag, " R5 nohit"}, longint'(res_nohit), nh);
        check({tag, " R6 pileup"}, longint'(res_pileup), pu);
        @(negedge clk);
        check({tag, " R7 single"}, longint'(res_valid), 0);
        check({tag, " R7 hold"}, longint'(res_peak), pk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int bases [3];
        int amps [3];
        bases = '{100, 8194, 15000};
        amps  = '{5, 400, 1300};
        for (int k = 0; k < 25; k++) hist[k] = 0;
        rst = 1'b1; smp_valid = 1'b0; win = 1'b0; smp_data = '0;
        cfg_min_peak = 14'd10; cfg_ratio_lo = 8'd16; cfg_ratio_hi = 8'd160;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check("R10 valid", longint'(res_valid), 0);
        check("R10 peak", longint'(res_peak), 0);
        check("R10 baseline", longint'(res_baseline), 0);
        check("R10 time", longint'(res_time), 0);
        check("R10 integral", longint'(res_integral), 0);

        // R1 partially filled history counts zeros
        fill_base(500, 0, 10);
        make_pulse(500, 900, 3, 5, 12, 24);
        run_window("r1_partial", 24, -1);

        // sweep: baseline x amplitude x rise length
        foreach (bases[bi]) foreach (amps[ai]) for (int r = 4; r <= 7; r += 1) begin
            if (r == 6) continue;
            fill_base(bases[bi], 3, 30);
            make_pulse(bases[bi], amps[ai], 6, r, 3 * r, 24);
            run_window("sweep", 24, -1);
        end

        // R2 R5 pulse below baseline: no hit
        fill_base(4000, 0, 30);
        make_pulse(4000, -500, 4, 5, 10, 20);
        run_window("r5_negative", 20, -1);

        // R5 min-peak boundary: exact peak 300
        cfg_min_peak = 14'd300;
        fill_base(1000, 0, 30);
        make_pulse(1000, 300, 4, 5, 10, 20);
        run_window("r5_at_min", 20, -1);
        cfg_min_peak = 14'd301;
        fill_base(1000, 0, 30);
        make_pulse(1000, 300, 4, 5, 10, 20);
        run_window("r5_below_min", 20, -1);
        cfg_min_peak = 14'd10;

        // R4 crossing at the first captured sample
        fill_base(2000, 2, 30);
        make_pulse(2000, 800, 0, 1, 8, 12);
        run_window("r4_first", 12, -1);

        // R9 overflow: samples beyond 32 are tall but ignored
        fill_base(3000, 1, 30);
        make_pulse(3000, 600, 5, 6, 15, 32);
        for (int k = 32; k < 40; k++) wv[k] = 16383;
        run_window("r9_overflow", 40, -1);
        // R9 overflow samples stayed out of the history
        make_pulse(3000, 600, 5, 6, 15, 24);
        run_window("r9_history", 24, -1);

        // R8 gaps inside the window are ignored
        fill_base(6000, 2, 30);
        make_pulse(6000, 1000, 3, 5, 12, 24);
        run_window("r8_gap", 24, 4);
        // R8 gaps before the window are ignored
        @(negedge clk); smp_valid = 1'b0; win = 1'b0; smp_data = 14'h3FFF;
        @(negedge clk);
        make_pulse(6000, 1000, 3, 5, 12, 24);
        run_window("r8_idle_gap", 24, -1);

        // R6 wide pulse exceeds the upper ratio
        fill_base(500, 0, 30);
        make_pulse(500, 1000, 1, 5, 26, 32);
        run_window("r6_wide", 32, -1);
        // R6 narrow pulse falls under a high lower bound
        cfg_ratio_lo = 8'd255;
        fill_base(500, 0, 30);
        make_pulse(500, 1000, 2, 4, 4, 12);
        run_window("r6_narrow", 12, -1);
        cfg_ratio_lo = 8'd16;

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule